// File: doc/BRIEF.md
# Mixed-Width Register Window Access Adapter

This block sits between a bus master and a 512-byte register window whose registers do not all have the same width. The master issues byte, halfword or word accesses. Each access must reach the registers as transfers of their own native width. The adapter splits each 4-byte group of the window by its native width, which a computed table supplies. It then picks one of three plans. An access of native width passes straight through. An access wider than the register is cut into several native transfers, the most significant part going to the lowest address. An access narrower than the register becomes a read of the whole register: for a read the addressed lanes are taken from it, and for a write they are merged into it and the register is written back.

Bus data is right-justified and byte order is big-endian throughout. The bus side takes one request at a time and stays busy until the response. This keeps a read-modify-write sequence indivisible. The register side presents a request, holds it until acknowledged, and carries right-justified data of the native width.

Top module: `regwin_width_adapter`

## Requirements
- R1: After reset, bus_ready is 1, bus_done is 0 and reg_req is 0.
- R2: The native width comes from the 4-byte group as follows. Offsets 0x000-0x07F are byte registers, 0x080-0x0FF are halfword, 0x100-0x17F are word, and 0x180-0x1BF hold no registers. In 0x1C0-0x1FF a group with address bit 2 clear is halfword and one with bit 2 set is byte. Every register-side transfer uses the native size of its group (reg_size 0 = byte, 1 = halfword, 2 = word).
- R3: An access at offset 0x200 or above completes with bus_err = 1 and makes no register-side transfer.
- R4: An access to a group with no registers completes with bus_err = 1 and makes no register-side transfer, so a write there changes nothing.
- R5: A bus_size of 3, a halfword at an odd offset, or a word at an offset that is not a multiple of 4 completes with bus_err = 1 and makes no register-side transfer.
- R6: An access of native width makes exactly one register transfer with the same offset, size and data.
- R7: A byte read from a wider register makes one read of the aligned register and returns the addressed byte. On a halfword register an even offset gives bits 15:8 and an odd offset gives bits 7:0. On a word register offset 0 through 3 gives bits 31:24 down to 7:0.
- R8: A byte or halfword write to a wider register makes one read and then one write of the aligned register. Only the addressed bytes change.
- R9: A halfword read from a word register returns bits 31:16 at a word-aligned offset and bits 15:0 at offset+2.
- R10: A halfword access to a byte register group makes two byte transfers. Bits 15:8 go to the lower address.
- R11: A word access to a narrower group makes word/native transfers at ascending addresses, the most significant part first: two for halfword groups, four for byte groups.
- R12: From the edge that accepts a request until after its response cycle, bus_ready stays 0 and a waiting request is not taken.
- R13: bus_done is a single-cycle pulse. It comes one cycle after acceptance for an error, and otherwise one cycle after the last acknowledged register transfer. bus_rdata holds the right-justified read data, zero-extended, and is zero for writes and errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Bus request, taken when bus_ready is 1 |
| bus_ready | output | 1 | Adapter idle and able to take a request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| bus_addr | input | ADDR_W (12) | Byte offset into the window |
| bus_wdata | input | 32 | Right-justified write data |
| bus_done | output | 1 | Response pulse |
| bus_err | output | 1 | Error flag, valid with bus_done |
| bus_rdata | output | 32 | Right-justified read data, valid with bus_done |
| reg_req | output | 1 | Register transfer request, held until reg_ack |
| reg_we | output | 1 | Register transfer is a write |
| reg_size | output | 2 | Native size of the transfer |
| reg_addr | output | $clog2(WIN_BYTES) (9) | Native-aligned register offset |
| reg_wdata | output | 32 | Right-justified native write data |
| reg_ack | input | 1 | Register side completes the transfer |
| reg_rdata | input | 32 | Right-justified native read data, valid with reg_ack |

## Verification
With a register side that acknowledges in the same cycle, the response to an access is due a fixed number of cycles after the accepting edge. Errors take one cycle. Other accesses take one cycle plus one per register transfer: two for a native access or a narrow read, three for a read-modify-write, three for a two-piece split and five for a four-piece split. The monitor samples just after each falling edge and counts cycles from acceptance and register handshakes up to bus_done. It then compares both counts with the figures the driver derived from the width map. Any early, late or extra transfer is therefore caught, along with wrong data.

// File: rtl/rwa_pkg.sv
// Package rwa_pkg
// Shared types and the native-width map of the register window.
// Assumes a window of 128 four-byte groups; groups past the map are absent.
package rwa_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_t;

    typedef enum logic [1:0] {
        NW_NONE = 2'd0,
        NW_BYTE = 2'd1,
        NW_HALF = 2'd2,
        NW_WORD = 2'd3
    } nat_width_t;

    typedef enum logic [1:0] {
        MD_ERROR  = 2'd0,
        MD_SPLIT  = 2'd1,
        MD_NARROW = 2'd2
    } plan_mode_t;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PIECE  = 3'd1,
        ST_RMW_RD = 3'd2,
        ST_RMW_WR = 3'd3,
        ST_RESP   = 3'd4
    } seq_state_t;

    localparam int unsigned GRP_HALF_START  = 32;
    localparam int unsigned GRP_WORD_START  = 64;
    localparam int unsigned GRP_HOLE_START  = 96;
    localparam int unsigned GRP_MIXED_START = 112;
    localparam int unsigned GRP_END         = 128;

    // Native width of one 4-byte group.
    function automatic nat_width_t group_native(input int unsigned grp);
        if (grp < GRP_HALF_START)       return NW_BYTE;
        else if (grp < GRP_WORD_START)  return NW_HALF;
        else if (grp < GRP_HOLE_START)  return NW_WORD;
        else if (grp < GRP_MIXED_START) return NW_NONE;
        else if (grp < GRP_END)         return (grp[0]) ? NW_BYTE : NW_HALF;
        else                            return NW_NONE;
    endfunction

    // Right-justified mask for a transfer of 2**lg bytes.
    function automatic logic [31:0] lane_mask(input logic [1:0] lg);
        case (lg)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/rwa_plan.sv
// Module rwa_plan
// Classifies a bus request: looks up the native width of the addressed
// group and decides between error, split (incl. equal width) and narrow
// read-modify-write/select. Purely combinational.
// Assumes ADDR_W is wider than the window offset so out-of-window
// addresses are representable.
module rwa_plan
    import rwa_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int WIN_BYTES = 512
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output plan_mode_t        mode,
    output logic [1:0]        nat_lg
);
    localparam int GROUPS = WIN_BYTES / 4;
    localparam int GRP_W  = $clog2(GROUPS);
    localparam logic [ADDR_W-1:0] WIN_LIMIT = ADDR_W'(WIN_BYTES);

    nat_width_t       width_tbl [GROUPS];
    nat_width_t       nw;
    logic             in_win;
    logic             misaligned;
    logic [GRP_W-1:0] grp;

    // One table entry per group, computed from the map function.
    for (genvar g = 0; g < GROUPS; g++) begin : g_tbl
        assign width_tbl[g] = group_native(g);
    end

    assign grp    = addr[GRP_W+1:2];
    assign in_win = (addr < WIN_LIMIT);

    // Lookup of the native width, absent outside the window.
    always_comb begin
        nw = in_win ? width_tbl[grp] : NW_NONE;
    end

    // Alignment rule of the bus-side size.
    always_comb begin
        case (size)
            2'd1:    misaligned = addr[0];
            2'd2:    misaligned = (addr[1:0] != 2'b00);
            default: misaligned = 1'b0;
        endcase
    end

    // Plan selection.
    always_comb begin
        nat_lg = 2'(nw) - 2'd1;
        if (!in_win || (size == 2'd3) || misaligned || (nw == NW_NONE)) begin
            mode = MD_ERROR;
        end else if (size < nat_lg) begin
            mode = MD_NARROW;
        end else begin
            mode = MD_SPLIT;
        end
    end

endmodule

// File: rtl/rwa_lanes.sv
// Module rwa_lanes
// Data and address path for the latched request: piece address and data
// for split transfers, read accumulation, lane select and merge for the
// narrow plan. Big-endian: the most significant part sits at the lowest
// address. Assumes sz >= nlg in split mode and sz < nlg in narrow mode.
module rwa_lanes
    import rwa_pkg::*;
#(
    parameter int WIN_AW = 9
) (
    input  logic [1:0]        sz,
    input  logic [1:0]        nlg,
    input  logic [WIN_AW-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [1:0]        k,
    input  logic [31:0]       acc,
    input  logic [31:0]       rdata,
    output logic [WIN_AW-1:0] piece_addr,
    output logic [WIN_AW-1:0] base_addr,
    output logic [31:0]       piece_wdata,
    output logic              piece_last,
    output logic [31:0]       acc_next,
    output logic [31:0]       narrow_sel,
    output logic [31:0]       narrow_merge
);
    int          s_b;
    int          n_b;
    int          d_lg;
    int          psh;
    int          nsh;
    int          off;
    logic [31:0] smask;
    logic [31:0] nmask;
    logic [31:0] wd;

    // Sizes, masks and masked write data.
    always_comb begin
        s_b   = int'(4'd1 << sz);
        n_b   = int'(4'd1 << nlg);
        d_lg  = int'(sz) - int'(nlg);
        smask = lane_mask(sz);
        nmask = lane_mask(nlg);
        wd    = wdata & smask;
    end

    // Split plan: address, data slice and last flag of piece k.
    always_comb begin
        psh = 8 * (s_b - n_b * (int'(k) + 1));
        if (psh < 0) psh = 0;
        piece_wdata = (wd >> psh) & nmask;
        piece_addr  = addr + WIN_AW'(int'(k) * n_b);
        piece_last  = (d_lg <= 0) || (int'(k) == ((1 << d_lg) - 1));
        acc_next    = (acc << (8 * n_b)) | (rdata & nmask);
    end

    // Narrow plan: aligned base, lane select and merged write data.
    always_comb begin
        base_addr    = addr & ~WIN_AW'(n_b - 1);
        off          = int'(addr[1:0]) & (n_b - 1);
        nsh          = 8 * (n_b - s_b - off);
        if (nsh < 0) nsh = 0;
        narrow_sel   = (rdata >> nsh) & smask;
        narrow_merge = (rdata & ~(smask << nsh)) | (wd << nsh);
    end

endmodule

// File: rtl/rwa_ctrl.sv
// Module rwa_ctrl
// Sequencer: accepts one bus request when idle, latches it, walks the
// register-side transfers of the chosen plan and issues a one-cycle
// response. The bus side stays busy for the whole sequence, which keeps
// read-modify-write indivisible. Assumes reg_rdata valid with reg_ack.
module rwa_ctrl
    import rwa_pkg::*;
#(
    parameter int WIN_AW = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [1:0]        bus_size,
    input  logic [WIN_AW-1:0] bus_addr_lo,
    input  logic [31:0]       bus_wdata,
    input  plan_mode_t        plan_mode,
    input  logic [1:0]        plan_nlg,
    input  logic              reg_ack,
    input  logic [WIN_AW-1:0] piece_addr,
    input  logic [WIN_AW-1:0] base_addr,
    input  logic [31:0]       piece_wdata,
    input  logic              piece_last,
    input  logic [31:0]       acc_next,
    input  logic [31:0]       narrow_sel,
    input  logic [31:0]       narrow_merge,
    output logic [1:0]        sz_q,
    output logic [1:0]        nlg_q,
    output logic [WIN_AW-1:0] addr_q,
    output logic [31:0]       wdata_q,
    output logic [1:0]        k_q,
    output logic [31:0]       acc_q,
    output logic              bus_ready,
    output logic              bus_done,
    output logic              bus_err,
    output logic [31:0]       bus_rdata,
    output logic              reg_req,
    output logic              reg_we,
    output logic [1:0]        reg_size,
    output logic [WIN_AW-1:0] reg_addr,
    output logic [31:0]       reg_wdata
);
    seq_state_t  state;
    logic        we_q;
    logic        err_q;
    logic [31:0] merge_q;

    // Sequencer state and request latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            we_q    <= 1'b0;
            err_q   <= 1'b0;
            sz_q    <= 2'd0;
            nlg_q   <= 2'd0;
            addr_q  <= '0;
            wdata_q <= '0;
            k_q     <= 2'd0;
            acc_q   <= '0;
            merge_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (bus_req) begin
                        we_q    <= bus_we;
                        sz_q    <= bus_size;
                        nlg_q   <= plan_nlg;
                        addr_q  <= bus_addr_lo;
                        wdata_q <= bus_wdata;
                        k_q     <= 2'd0;
                        acc_q   <= '0;
                        err_q   <= (plan_mode == MD_ERROR);
                        case (plan_mode)
                            MD_SPLIT:  state <= ST_PIECE;
                            MD_NARROW: state <= ST_RMW_RD;
                            default:   state <= ST_RESP;
                        endcase
                    end
                end
                ST_PIECE: begin
                    if (reg_ack) begin
                        if (!we_q) acc_q <= acc_next;
                        if (piece_last) state <= ST_RESP;
                        else            k_q   <= k_q + 2'd1;
                    end
                end
                ST_RMW_RD: begin
                    if (reg_ack) begin
                        if (we_q) begin
                            merge_q <= narrow_merge;
                            state   <= ST_RMW_WR;
                        end else begin
                            acc_q <= narrow_sel;
                            state <= ST_RESP;
                        end
                    end
                end
                ST_RMW_WR: begin
                    if (reg_ack) state <= ST_RESP;
                end
                ST_RESP: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Bus-side outputs.
    always_comb begin
        bus_ready = (state == ST_IDLE);
        bus_done  = (state == ST_RESP);
        bus_err   = (state == ST_RESP) && err_q;
        bus_rdata = acc_q;
    end

    // Register-side transfer for the current state.
    always_comb begin
        reg_req   = 1'b0;
        reg_we    = 1'b0;
        reg_size  = nlg_q;
        reg_addr  = base_addr;
        reg_wdata = '0;
        case (state)
            ST_PIECE: begin
                reg_req   = 1'b1;
                reg_we    = we_q;
                reg_addr  = piece_addr;
                reg_wdata = we_q ? piece_wdata : 32'd0;
            end
            ST_RMW_RD: begin
                reg_req = 1'b1;
            end
            ST_RMW_WR: begin
                reg_req   = 1'b1;
                reg_we    = 1'b1;
                reg_wdata = merge_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/regwin_width_adapter.sv
// Module regwin_width_adapter
// Top of the mixed-width access adapter: bus-side requests of 8, 16 or
// 32 bits are mapped onto native-width register transfers of a window
// of WIN_BYTES bytes. Assumes a single outstanding bus request.
module regwin_width_adapter
    import rwa_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int WIN_BYTES = 512,
    localparam int WIN_AW   = $clog2(WIN_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    output logic              bus_ready,
    input  logic              bus_we,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_done,
    output logic              bus_err,
    output logic [31:0]       bus_rdata,
    output logic              reg_req,
    output logic              reg_we,
    output logic [1:0]        reg_size,
    output logic [WIN_AW-1:0] reg_addr,
    output logic [31:0]       reg_wdata,
    input  logic              reg_ack,
    input  logic [31:0]       reg_rdata
);
    plan_mode_t        plan_mode;
    logic [1:0]        plan_nlg;
    logic [1:0]        sz_q;
    logic [1:0]        nlg_q;
    logic [WIN_AW-1:0] addr_q;
    logic [31:0]       wdata_q;
    logic [1:0]        k_q;
    logic [31:0]       acc_q;
    logic [WIN_AW-1:0] piece_addr;
    logic [WIN_AW-1:0] base_addr;
    logic [31:0]       piece_wdata;
    logic              piece_last;
    logic [31:0]       acc_next;
    logic [31:0]       narrow_sel;
    logic [31:0]       narrow_merge;

    rwa_plan #(
        .ADDR_W   (ADDR_W),
        .WIN_BYTES(WIN_BYTES)
    ) plan_i (
        .addr  (bus_addr),
        .size  (bus_size),
        .mode  (plan_mode),
        .nat_lg(plan_nlg)
    );

    rwa_lanes #(
        .WIN_AW(WIN_AW)
    ) lanes_i (
        .sz          (sz_q),
        .nlg         (nlg_q),
        .addr        (addr_q),
        .wdata       (wdata_q),
        .k           (k_q),
        .acc         (acc_q),
        .rdata       (reg_rdata),
        .piece_addr  (piece_addr),
        .base_addr   (base_addr),
        .piece_wdata (piece_wdata),
        .piece_last  (piece_last),
        .acc_next    (acc_next),
        .narrow_sel  (narrow_sel),
        .narrow_merge(narrow_merge)
    );

    rwa_ctrl #(
        .WIN_AW(WIN_AW)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_size    (bus_size),
        .bus_addr_lo (bus_addr[WIN_AW-1:0]),
        .bus_wdata   (bus_wdata),
        .plan_mode   (plan_mode),
        .plan_nlg    (plan_nlg),
        .reg_ack     (reg_ack),
        .piece_addr  (piece_addr),
        .base_addr   (base_addr),
        .piece_wdata (piece_wdata),
        .piece_last  (piece_last),
        .acc_next    (acc_next),
        .narrow_sel  (narrow_sel),
        .narrow_merge(narrow_merge),
        .sz_q        (sz_q),
        .nlg_q       (nlg_q),
        .addr_q      (addr_q),
        .wdata_q     (wdata_q),
        .k_q         (k_q),
        .acc_q       (acc_q),
        .bus_ready   (bus_ready),
        .bus_done    (bus_done),
        .bus_err     (bus_err),
        .bus_rdata   (bus_rdata),
        .reg_req     (reg_req),
        .reg_we      (reg_we),
        .reg_size    (reg_size),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata)
    );

endmodule

// File: rtl/regwin_width_adapter_chk.sv
// Module regwin_width_adapter_chk
// Protocol checker bound to regwin_width_adapter. Observes ports only.
// Assumes synchronous active-low reset.
module regwin_width_adapter_chk
    import rwa_pkg::*;
#(
    parameter int WIN_BYTES = 512,
    localparam int WIN_AW   = $clog2(WIN_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_ready,
    input logic              bus_done,
    input logic              bus_err,
    input logic              reg_req,
    input logic              reg_we,
    input logic [1:0]        reg_size,
    input logic [WIN_AW-1:0] reg_addr,
    input logic              reg_ack
);
    logic [1:0] exp_lg;

    // Native size the map expects at the register-side offset.
    always_comb begin
        exp_lg = 2'(group_native(int'(reg_addr[WIN_AW-1:2]))) - 2'd1;
    end

    AST_REG_NATIVE_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |-> (reg_size == exp_lg)); // R2

    AST_ERR_NO_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_done && bus_err) |-> (!reg_req && !$past(reg_req))); // R3

    AST_REG_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |-> ((reg_size != 2'd3) &&
                     ((reg_addr & WIN_AW'((1 << reg_size) - 1)) == '0))); // R6

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) &&
                                   $stable(reg_we) && $stable(reg_size))); // R8

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req || bus_done) |-> !bus_ready); // R12

    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ready) |=> !bus_ready); // R12

    AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_done |=> !bus_done); // R13

endmodule

bind regwin_width_adapter regwin_width_adapter_chk #(
    .WIN_BYTES(WIN_BYTES)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_ready(bus_ready),
    .bus_done (bus_done),
    .bus_err  (bus_err),
    .reg_req  (reg_req),
    .reg_we   (reg_we),
    .reg_size (reg_size),
    .reg_addr (reg_addr),
    .reg_ack  (reg_ack)
);

// File: tb/regwin_width_adapter_tb_top.sv
// Scoreboard bench: the driver computes each expected response from the
// width map and a shadow copy of the registers; the monitor compares the
// response, its latency and the number of register transfers.
module regwin_width_adapter_tb_top;

    localparam int ADDR_W    = 12;
    localparam int WIN_BYTES = 512;
    localparam int WIN_AW    = $clog2(WIN_BYTES);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_req = 1'b0;
    logic              bus_ready;
    logic              bus_we = 1'b0;
    logic [1:0]        bus_size = 2'd0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_done;
    logic              bus_err;
    logic [31:0]       bus_rdata;
    logic              reg_req;
    logic              reg_we;
    logic [1:0]        reg_size;
    logic [WIN_AW-1:0] reg_addr;
    logic [31:0]       reg_wdata;
    logic              reg_ack;
    logic [31:0]       reg_rdata;

    always #2 clk = ~clk;

    regwin_width_adapter #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_ready(bus_ready), .bus_we(bus_we),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_done(bus_done), .bus_err(bus_err), .bus_rdata(bus_rdata),
        .reg_req(reg_req), .reg_we(reg_we), .reg_size(reg_size),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_ack(reg_ack), .reg_rdata(reg_rdata)
    );

    int n_checks = 0;
    int n_fail   = 0;

    function automatic logic [7:0] init_byte(input int i);
        return 8'(i * 7 + 3);
    endfunction

    // Width map from R2: returns log2 bytes, or -1 when absent.
    function automatic int map_lg(input int a);
        if (a < 'h080) return 0;
        if (a < 'h100) return 1;
        if (a < 'h180) return 2;
        if (a < 'h1C0) return -1;
        if (a < 'h200) return ((a >> 2) & 1) ? 0 : 1;
        return -1;
    endfunction

    // Register file model, acknowledged in the same cycle.
    logic [7:0] regmem [WIN_BYTES];
    assign reg_ack = reg_req;

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < 4; i++)
            if (i < (1 << reg_size))
                reg_rdata = (reg_rdata << 8) | 32'(regmem[(int'(reg_addr) + i) % WIN_BYTES]);
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WIN_BYTES; i++) regmem[i] <= init_byte(i);
        end else if (reg_req && reg_ack && reg_we) begin
            for (int i = 0; i < 4; i++)
                if (i < (1 << reg_size))
                    regmem[(int'(reg_addr) + i) % WIN_BYTES] <=
                        8'(reg_wdata >> (8 * ((1 << reg_size) - 1 - i)));
        end
    end

    // Shadow of the register contents, updated by the driver.
    logic [7:0] shadow [WIN_BYTES];
    initial for (int i = 0; i < WIN_BYTES; i++) shadow[i] = init_byte(i);

    typedef struct {
        logic        err;
        logic [31:0] rdata;
        int          nacc;
        int          lat;
        string       tag;
    } exp_t;

    exp_t sbq[$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: compute expectation, present the request, wait for acceptance.
    task automatic issue(input logic we, input logic [1:0] sz, input int a,
                         input logic [31:0] wd, input string tag, input bit hold);
        exp_t e;
        int   nl;
        int   sb;
        bit   bad;
        nl  = map_lg(a);
        sb  = 1 << sz;
        bad = (a >= WIN_BYTES) || (sz == 2'd3) || ((a % sb) != 0) || (nl < 0);
        e.tag   = tag;
        e.rdata = '0;
        e.err   = bad;
        if (bad) begin
            e.nacc = 0;
        end else if (int'(sz) >= nl) begin
            e.nacc = 1 << (int'(sz) - nl);
        end else begin
            e.nacc = we ? 2 : 1;
        end
        e.lat = 1 + e.nacc;
        bus_we    = we;
        bus_size  = sz;
        bus_addr  = ADDR_W'(a);
        bus_wdata = wd;
        bus_req   = 1'b1;
        while (!bus_ready) @(negedge clk);
        if (!bad) begin
            for (int i = 0; i < sb; i++) begin
                if (we) shadow[a + i] = 8'(wd >> (8 * (sb - 1 - i)));
                else    e.rdata = (e.rdata << 8) | 32'(shadow[a + i]);
            end
        end
        sbq.push_back(e);
        @(negedge clk);
        if (!hold) bus_req = 1'b0;
    endtask

    // Monitor: latency, transfer count, response fields.
    bit busy = 1'b0;
    bit ready_seen = 1'b0;
    int cyc = 0;
    int nacc = 0;

    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (busy) begin
                cyc++;
                if (bus_ready) ready_seen = 1'b1;
            end
            if (reg_req && reg_ack) begin
                nacc++;
                check("R2 native reg_size", 32'(reg_size), 32'(map_lg(int'(reg_addr))));
            end
            if (bus_done) begin
                if (sbq.size() == 0) begin
                    check("R13 unexpected response", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    check({e.tag, " err"},   32'(bus_err), 32'(e.err));
                    check({e.tag, " rdata"}, bus_rdata, e.rdata);
                    check({e.tag, " reg transfers"}, 32'(nacc), 32'(e.nacc));
                    check({e.tag, " R13 latency"},   32'(cyc),  32'(e.lat));
                    check({e.tag, " R12 ready low"}, 32'(ready_seen), 32'd0);
                end
                busy = 1'b0;
            end
            if (bus_req && bus_ready) begin
                busy = 1'b1;
                cyc = 0;
                nacc = 0;
                ready_seen = 1'b0;
            end
        end
    end

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 bus_ready", 32'(bus_ready), 32'd1);
        check("R1 bus_done",  32'(bus_done),  32'd0);
        check("R1 reg_req",   32'(reg_req),   32'd0);

        // R6 native width
        issue(1'b0, 2'd0, 'h010, 0, "R6 byte rd", 0);
        issue(1'b0, 2'd1, 'h080, 0, "R6 half rd", 0);
        issue(1'b0, 2'd2, 'h100, 0, "R6 word rd", 0);
        issue(1'b1, 2'd1, 'h082, 32'h0000_BEEF, "R6 half wr", 0);
        issue(1'b0, 2'd1, 'h082, 0, "R6 half rdback", 0);
        // R7 byte from wider
        issue(1'b0, 2'd0, 'h084, 0, "R7 even byte of half", 0);
        issue(1'b0, 2'd0, 'h085, 0, "R7 odd byte of half", 0);
        issue(1'b0, 2'd0, 'h102, 0, "R7 byte2 of word", 0);
        issue(1'b0, 2'd0, 'h103, 0, "R7 byte3 of word", 0);
        // R8 narrow writes
        issue(1'b1, 2'd0, 'h087, 32'hFFFF_FFA5, "R8 byte wr half", 0);
        issue(1'b0, 2'd1, 'h086, 0, "R8 half rdback", 0);
        issue(1'b1, 2'd0, 'h110, 32'h0000_005A, "R8 byte wr word", 0);
        issue(1'b1, 2'd1, 'h10A, 32'h1234_C0DE, "R8 half wr word", 0);
        issue(1'b0, 2'd2, 'h108, 0, "R8 word rdback", 0);
        issue(1'b0, 2'd2, 'h110, 0, "R8 word rdback2", 0);
        // R9 half from word
        issue(1'b0, 2'd1, 'h104, 0, "R9 upper half", 0);
        issue(1'b0, 2'd1, 'h106, 0, "R9 lower half", 0);
        // R10 half split to bytes
        issue(1'b0, 2'd1, 'h020, 0, "R10 half rd bytes", 0);
        issue(1'b1, 2'd1, 'h022, 32'h0000_A1B2, "R10 half wr bytes", 0);
        issue(1'b0, 2'd0, 'h022, 0, "R10 high byte low addr", 0);
        issue(1'b0, 2'd0, 'h023, 0, "R10 low byte", 0);
        // R11 word split
        issue(1'b0, 2'd2, 'h088, 0, "R11 word rd halves", 0);
        issue(1'b1, 2'd2, 'h040, 32'hDEAD_F00D, "R11 word wr bytes", 0);
        issue(1'b0, 2'd0, 'h040, 0, "R11 MSB at low addr", 0);
        issue(1'b0, 2'd2, 'h040, 0, "R11 word rd bytes", 0);
        issue(1'b0, 2'd2, 'h1C0, 0, "R11 mixed half group", 0);
        issue(1'b1, 2'd2, 'h1C4, 32'h0102_0304, "R11 mixed byte group", 0);
        issue(1'b0, 2'd1, 'h1C6, 0, "R11 mixed rdback", 0);
        // R3 R4 R5 errors
        issue(1'b0, 2'd0, 'h200, 0, "R3 window end", 0);
        issue(1'b1, 2'd2, 'h7FC, 32'h5555_5555, "R3 far offset", 0);
        issue(1'b1, 2'd2, 'h184, 32'hAAAA_AAAA, "R4 absent wr", 0);
        issue(1'b0, 2'd0, 'h1BF, 0, "R4 absent rd", 0);
        issue(1'b0, 2'd1, 'h081, 0, "R5 odd half", 0);
        issue(1'b1, 2'd2, 'h102, 32'h7777_7777, "R5 misaligned word", 0);
        issue(1'b0, 2'd3, 'h100, 0, "R5 size 3", 0);
        issue(1'b0, 2'd2, 'h100, 0, "R5 no write rdback", 0);
        // R12 back-to-back with request held during RMW
        issue(1'b1, 2'd0, 'h0F1, 32'h0000_0033, "R12 rmw held", 1);
        issue(1'b0, 2'd1, 'h0F0, 0, "R12 queued rd", 1);
        issue(1'b0, 2'd2, 'h000, 0, "R12 queued split", 0);

        while (sbq.size() != 0 || busy) @(negedge clk);
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule